// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block holds the eight status flags of an I2C controller and presents them as one packed byte for the CPU to read. It has no bus pins of its own. A separate bus engine feeds it single-cycle event strobes: a start condition it generated, start and stop conditions it saw on the bus, a lost arbitration, the rise of the eighth SCL clock together with the received address byte, and the rise of the ninth SCL clock together with the sampled SDA level. A level input gives the transfer direction. The controller's enable bit, a release request and a CPU read strobe also come in from outside.

Each flag has its own set and clear events. When both arrive in the same cycle, the clear takes effect, with one exception: a CPU read that would clear the arbitration flag gives way to a new arbitration loss. On the eighth clock the block decides whether the address byte is an extension code, meaning its upper nibble is all zeros or all ones. It also decides whether the byte equals the programmed local slave address. The block has no write path, so software can only read the status byte. Every flag changes on the clock edge that follows its event.

Top module: `i2c_stat_reg`

## Requirements
- R1: Reset drives `status` to 8'h00. Bit layout, MSB first: [7] master, [6] arbitration lost, [5] extension code, [4] address match, [3] transmit, [2] acknowledge, [1] start seen, [0] stop seen.
- R2: Bit 7 sets one cycle after `start_gen`. It clears one cycle after `stop_seen`, `arb_lost`, `bus_release`, or a 1-to-0 transition of `enable`. A clear wins over a set in the same cycle.
- R3: `arb_lost` with `enable`=1 sets bit 6 and clears bit 7 on the next cycle.
- R4: Bit 6 clears on `cpu_rd`, and it clears while `enable` is 0. If `cpu_rd` and `arb_lost` arrive in the same cycle, bit 6 stays 1.
- R5: On `clk8_rise`, bit 5 sets if `rx_addr[7:4]` is 4'b0000 or 4'b1111.
- R6: Bit 5 clears on `start_seen`, `stop_seen` or `bus_release`, and it clears while `enable` is 0. Each of these wins over a same-cycle set. While `enable` is 0, bits 6, 5, 4, 1 and 0 read 0.
- R7: On `clk8_rise`, bit 4 sets if `rx_addr` equals `own_addr`.
- R8: Bit 4 clears on `start_seen` or `bus_release`, and it clears while `enable` is 0. `stop_seen` leaves it unchanged.
- R9: Bit 1 sets on `start_seen` and clears on `stop_seen`. Bit 0 sets on `stop_seen` and clears on `start_seen`. Clear wins, so both strobes together leave both bits at 0.
- R10: On `clk9_rise`, bit 2 loads the inverse of `sda_in` (SDA low means acknowledge). `start_seen` or `stop_seen` clears it and wins over a load.
- R11: Bit 3 equals the value `tx_mode` had in the previous cycle (1 means transmitting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable bit |
| bus_release | input | 1 | Release request from the control register |
| cpu_rd | input | 1 | One-cycle strobe for a CPU read of the status byte |
| start_gen | input | 1 | Strobe: this controller generated a start |
| start_seen | input | 1 | Strobe: start condition detected on the bus |
| stop_seen | input | 1 | Strobe: stop condition detected on the bus |
| arb_lost | input | 1 | Strobe: arbitration lost |
| clk8_rise | input | 1 | Strobe: rising edge of the eighth SCL clock |
| clk9_rise | input | 1 | Strobe: rising edge of the ninth SCL clock |
| sda_in | input | 1 | SDA level, sampled with `clk9_rise` |
| tx_mode | input | 1 | Transfer direction, 1 = transmit |
| rx_addr | input | ADDR_W | Received address byte, valid with `clk8_rise` |
| own_addr | input | ADDR_W | Programmed local slave address |
| status | output | 8 | Packed status byte |

## Verification
The assertions assume the bus engine sends each event as a one-cycle strobe. They also assume `rx_addr` is valid whenever `clk8_rise` is high and `sda_in` is valid whenever `clk9_rise` is high. They do not assume that events are mutually exclusive.

The stimulus sends strobes on a single negative edge and clears them before the next one. It holds the address and SDA inputs steady around the eighth and ninth clock strobes. It deliberately pairs colliding events in one cycle (set with clear, read with arbitration loss, start with stop) so the priority rules are actually exercised.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

  localparam int STAT_W = 8;

  // Slots of the flags built from a generic set/clear cell.
  localparam int SC_N    = 6;
  localparam int SC_MSTR = 0;
  localparam int SC_ARBL = 1;
  localparam int SC_XCOD = 2;
  localparam int SC_AMAT = 3;
  localparam int SC_STRT = 4;
  localparam int SC_STOP = 5;

  // One bit per slot: 1 means a set beats a same-cycle clear.
  localparam logic [SC_N-1:0] SC_SET_WINS = 6'b00_0010;

  // Field order is the register's bit order, MSB first.
  typedef struct packed {
    logic mstr;
    logic arbl;
    logic xcod;
    logic amat;
    logic xmit;
    logic ackd;
    logic strt;
    logic stop;
  } stat_t;

endpackage

// File: rtl/i2c_stat_addr.sv
module i2c_stat_addr #(
  parameter int ADDR_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              ext_hit,
  output logic              own_hit
);

  function automatic logic f_ext_code(input logic [ADDR_W-1:0] a);
    logic [NIB_W-1:0] hi;
    hi = a[ADDR_W-1 -: NIB_W];
    return (hi == '0) || (hi == '1);
  endfunction

  function automatic logic f_same(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  assign ext_hit = f_ext_code(rx_addr);
  assign own_hit = f_same(rx_addr, own_addr);

endmodule

// File: rtl/i2c_stat_flag.sv
module i2c_stat_flag #(
  parameter bit SET_WINS = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  logic q_nxt;

  generate
    if (SET_WINS) begin : g_set_prio
      always_comb begin
        if (set)      q_nxt = 1'b1;
        else if (clr) q_nxt = 1'b0;
        else          q_nxt = q;
      end
    end else begin : g_clr_prio
      always_comb begin
        if (clr)      q_nxt = 1'b0;
        else if (set) q_nxt = 1'b1;
        else          q_nxt = q;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/i2c_stat_evt.sv
module i2c_stat_evt
  import i2c_stat_pkg::*;
(
  input  logic            enable,
  input  logic            en_fall,
  input  logic            bus_release,
  input  logic            cpu_rd,
  input  logic            start_gen,
  input  logic            start_seen,
  input  logic            stop_seen,
  input  logic            arb_lost,
  input  logic            clk8_rise,
  input  logic            ext_hit,
  input  logic            own_hit,
  output logic [SC_N-1:0] set_vec,
  output logic [SC_N-1:0] clr_vec
);

  always_comb begin
    set_vec = '0;
    clr_vec = '0;

    set_vec[SC_MSTR] = start_gen;
    clr_vec[SC_MSTR] = stop_seen | arb_lost | bus_release | en_fall;

    // The enable gate on the set keeps a disabled controller cleared
    // even though this slot lets a set beat a read-clear.
    set_vec[SC_ARBL] = arb_lost & enable;
    clr_vec[SC_ARBL] = ~enable | cpu_rd;

    set_vec[SC_XCOD] = clk8_rise & ext_hit;
    clr_vec[SC_XCOD] = start_seen | stop_seen | bus_release | ~enable;

    set_vec[SC_AMAT] = clk8_rise & own_hit;
    clr_vec[SC_AMAT] = start_seen | bus_release | ~enable;

    set_vec[SC_STRT] = start_seen;
    clr_vec[SC_STRT] = stop_seen | ~enable;

    set_vec[SC_STOP] = stop_seen;
    clr_vec[SC_STOP] = start_seen | ~enable;
  end

endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
  import i2c_stat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              bus_release,
  input  logic              cpu_rd,
  input  logic              start_gen,
  input  logic              start_seen,
  input  logic              stop_seen,
  input  logic              arb_lost,
  input  logic              clk8_rise,
  input  logic              clk9_rise,
  input  logic              sda_in,
  input  logic              tx_mode,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] own_addr,
  output logic [STAT_W-1:0] status
);

  // Named internal events, also used by the bound checker.
  logic            en_q;
  logic            en_fall;
  logic            ext_hit;
  logic            own_hit;
  logic [SC_N-1:0] set_vec;
  logic [SC_N-1:0] clr_vec;
  logic [SC_N-1:0] sc_q;
  logic            xmit_q;
  logic            ackd_q;
  stat_t           stat_s;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable;
  end

  assign en_fall = en_q & ~enable;

  i2c_stat_addr #(
    .ADDR_W (ADDR_W),
    .NIB_W  (NIB_W)
  ) u_addr (
    .rx_addr  (rx_addr),
    .own_addr (own_addr),
    .ext_hit  (ext_hit),
    .own_hit  (own_hit)
  );

  i2c_stat_evt u_evt (
    .enable      (enable),
    .en_fall     (en_fall),
    .bus_release (bus_release),
    .cpu_rd      (cpu_rd),
    .start_gen   (start_gen),
    .start_seen  (start_seen),
    .stop_seen   (stop_seen),
    .arb_lost    (arb_lost),
    .clk8_rise   (clk8_rise),
    .ext_hit     (ext_hit),
    .own_hit     (own_hit),
    .set_vec     (set_vec),
    .clr_vec     (clr_vec)
  );

  generate
    for (genvar g = 0; g < SC_N; g++) begin : g_flag
      i2c_stat_flag #(
        .SET_WINS (SC_SET_WINS[g])
      ) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_vec[g]),
        .clr   (clr_vec[g]),
        .q     (sc_q[g])
      );
    end
  endgenerate

  // Acknowledge: a load on the ninth clock, cleared by bus conditions.
  always_ff @(posedge clk) begin
    if (!rst_n)                        ackd_q <= 1'b0;
    else if (start_seen || stop_seen)  ackd_q <= 1'b0;
    else if (clk9_rise)                ackd_q <= ~sda_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) xmit_q <= 1'b0;
    else        xmit_q <= tx_mode;
  end

  always_comb begin
    stat_s      = '0;
    stat_s.mstr = sc_q[SC_MSTR];
    stat_s.arbl = sc_q[SC_ARBL];
    stat_s.xcod = sc_q[SC_XCOD];
    stat_s.amat = sc_q[SC_AMAT];
    stat_s.xmit = xmit_q;
    stat_s.ackd = ackd_q;
    stat_s.strt = sc_q[SC_STRT];
    stat_s.stop = sc_q[SC_STOP];
  end

  assign status = stat_s;

endmodule

// File: rtl/i2c_stat_reg_chk.sv
module i2c_stat_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       bus_release,
  input logic       cpu_rd,
  input logic       start_gen,
  input logic       start_seen,
  input logic       stop_seen,
  input logic       arb_lost,
  input logic       clk8_rise,
  input logic       clk9_rise,
  input logic       sda_in,
  input logic       tx_mode,
  input logic       en_fall,
  input logic       ext_hit,
  input logic       own_hit,
  input logic [7:0] status
);

  p_mstr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_gen && !stop_seen && !arb_lost && !bus_release && !en_fall) |=> status[7]);

  p_mstr_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen || arb_lost || bus_release || en_fall) |=> !status[7]);

  p_arbl_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && arb_lost) |=> (status[6] && !status[7]));

  p_arbl_rdclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !arb_lost) |=> !status[6]);

  p_xcod_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clk8_rise && ext_hit && !start_seen && !stop_seen && !bus_release)
      |=> status[5]);

  p_xcod_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen || stop_seen || bus_release) |=> !status[5]);

  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (status[6:4] == 3'b000 && status[1:0] == 2'b00));

  p_amat_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clk8_rise && own_hit && !start_seen && !bus_release) |=> status[4]);

  p_amat_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && status[4] && stop_seen && !start_seen && !bus_release) |=> status[4]);

  p_amat_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen || bus_release) |=> !status[4]);

  p_cond_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status[1:0]));

  p_ackd_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk9_rise && !start_seen && !stop_seen) |=> (status[2] == !$past(sda_in)));

  p_xmit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (status[3] == $past(tx_mode)));

endmodule

bind i2c_stat_reg i2c_stat_reg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .bus_release (bus_release),
  .cpu_rd      (cpu_rd),
  .start_gen   (start_gen),
  .start_seen  (start_seen),
  .stop_seen   (stop_seen),
  .arb_lost    (arb_lost),
  .clk8_rise   (clk8_rise),
  .clk9_rise   (clk9_rise),
  .sda_in      (sda_in),
  .tx_mode     (tx_mode),
  .en_fall     (en_fall),
  .ext_hit     (ext_hit),
  .own_hit     (own_hit),
  .status      (status)
);

// File: tb/i2c_stat_reg_test.sv
module i2c_stat_reg_test;

  typedef struct packed {
    logic       en;
    logic       rel;
    logic       rd;
    logic       sgen;
    logic       sdet;
    logic       pdet;
    logic       arb;
    logic       c8;
    logic       c9;
    logic       sda;
    logic       dir;
    logic [7:0] rx;
    logic [7:0] sla;
  } stim_t;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  stim_t      cur;
  stim_t      nxt;
  logic [7:0] status;

  sb_item_t   sb_q[$];
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  // Reference state, written from the requirement text.
  bit m_master, m_lost, m_ext, m_match, m_tx, m_ack, m_st, m_sp, m_en_prev;

  always #10 clk = ~clk;

  i2c_stat_reg uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (cur.en),
    .bus_release (cur.rel),
    .cpu_rd      (cur.rd),
    .start_gen   (cur.sgen),
    .start_seen  (cur.sdet),
    .stop_seen   (cur.pdet),
    .arb_lost    (cur.arb),
    .clk8_rise   (cur.c8),
    .clk9_rise   (cur.c9),
    .sda_in      (cur.sda),
    .tx_mode     (cur.dir),
    .rx_addr     (cur.rx),
    .own_addr    (cur.sla),
    .status      (status)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: status=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Flags after one clock edge with the stimulus in cur.
  task automatic model_step();
    bit fell;
    bit hi_ext;
    fell   = m_en_prev && !cur.en;
    hi_ext = (cur.rx[7:4] == 4'h0) || (cur.rx[7:4] == 4'hF);
    // R2 master
    if (cur.pdet || cur.arb || cur.rel || fell) m_master = 0;
    else if (cur.sgen)                           m_master = 1;
    // R3/R4 arbitration lost
    if (!cur.en)       m_lost = 0;
    else if (cur.arb)  m_lost = 1;
    else if (cur.rd)   m_lost = 0;
    // R5/R6 extension code
    if (cur.sdet || cur.pdet || cur.rel || !cur.en) m_ext = 0;
    else if (cur.c8 && hi_ext)                      m_ext = 1;
    // R7/R8 address match
    if (cur.sdet || cur.rel || !cur.en)    m_match = 0;
    else if (cur.c8 && cur.rx == cur.sla)  m_match = 1;
    // R11 direction
    m_tx = cur.dir;
    // R10 acknowledge
    if (cur.sdet || cur.pdet) m_ack = 0;
    else if (cur.c9)          m_ack = !cur.sda;
    // R9 start / stop seen
    if (cur.pdet || !cur.en) m_st = 0;
    else if (cur.sdet)       m_st = 1;
    if (cur.sdet || !cur.en) m_sp = 0;
    else if (cur.pdet)       m_sp = 1;
    m_en_prev = cur.en;
  endtask

  // Driver: apply nxt for one cycle and queue the expected byte.
  task automatic cycle(input string tag);
    @(negedge clk);
    cur = nxt;
    model_step();
    sb_q.push_back('{exp: {m_master, m_lost, m_ext, m_match, m_tx, m_ack, m_st, m_sp},
                     tag: tag});
    nxt.rel  = 0; nxt.rd   = 0; nxt.sgen = 0; nxt.sdet = 0;
    nxt.pdet = 0; nxt.arb  = 0; nxt.c8   = 0; nxt.c9   = 0;
  endtask

  // Monitor: compare mid-way through the high phase after each edge.
  initial begin
    sb_item_t it;
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() != 0) begin
        it = sb_q.pop_front();
        check(status === it.exp, it.tag, status, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: status=%02h expected=done", status);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    nxt = '0;
    nxt.sda = 1'b1;
    nxt.sla = 8'h5A;
    cur = nxt;
    {m_master, m_lost, m_ext, m_match, m_tx, m_ack, m_st, m_sp, m_en_prev} = '0;

    repeat (3) @(negedge clk);
    check(status === 8'h00, "R1 reset", status, 8'h00);
    rst_n = 1'b1;
    cycle("R1 idle after reset");

    // Master flag
    nxt.en = 1; cycle("R2 enable");
    nxt.sgen = 1; cycle("R2 start generated");
    nxt.pdet = 1; cycle("R2 stop clears master");
    nxt.sgen = 1; cycle("R2 set again");
    nxt.rel = 1; cycle("R2 release clears");
    nxt.sgen = 1; cycle("R2 set before disable");
    nxt.en = 0; cycle("R2 enable fall clears");
    nxt.en = 1; cycle("R2 re-enable");
    nxt.sgen = 1; nxt.arb = 1; cycle("R2 clear beats set");

    // Arbitration lost
    nxt.sgen = 1; cycle("R3 master before loss");
    nxt.arb = 1; cycle("R3 loss sets flag clears master");
    nxt.rd = 1; cycle("R4 read clears");
    nxt.arb = 1; cycle("R4 loss again");
    nxt.arb = 1; nxt.rd = 1; cycle("R4 loss beats read");
    nxt.en = 0; cycle("R4 disable clears");
    nxt.en = 1; nxt.arb = 1; cycle("R4 loss while enabled");
    cycle("R4 flag held");

    // Extension code
    nxt.rx = 8'h07; nxt.c8 = 1; cycle("R5 nibble 0000");
    nxt.sdet = 1; cycle("R6 start clears ext");
    nxt.rx = 8'hF3; nxt.c8 = 1; cycle("R5 nibble 1111");
    nxt.pdet = 1; cycle("R6 stop clears ext");
    nxt.rx = 8'h65; nxt.c8 = 1; cycle("R5 ordinary nibble");
    nxt.rx = 8'h0C; nxt.c8 = 1; cycle("R5 set before release");
    nxt.rel = 1; cycle("R6 release clears");
    nxt.c8 = 1; nxt.sdet = 1; cycle("R6 clear beats set");
    nxt.c8 = 1; cycle("R5 set before disable");
    nxt.en = 0; cycle("R6 disable clears");
    nxt.en = 0; nxt.c8 = 1; cycle("R6 no set while disabled");
    nxt.en = 1; cycle("R6 re-enable");

    // Address match
    nxt.rx = 8'h5A; nxt.c8 = 1; cycle("R7 address equal");
    nxt.pdet = 1; cycle("R8 stop keeps match");
    nxt.sdet = 1; cycle("R8 start clears match");
    nxt.c8 = 1; cycle("R7 match again");
    nxt.rel = 1; cycle("R8 release clears match");
    nxt.rx = 8'h5B; nxt.c8 = 1; cycle("R7 address differs");
    nxt.sla = 8'h0F; nxt.rx = 8'h0F; nxt.c8 = 1; cycle("R7 match and ext code");
    nxt.en = 0; cycle("R8 disable clears match");
    nxt.en = 1; nxt.sla = 8'h5A; cycle("R8 re-enable");

    // Start / stop seen
    nxt.sdet = 1; cycle("R9 start seen");
    nxt.pdet = 1; cycle("R9 stop seen");
    nxt.sdet = 1; cycle("R9 start after stop");
    nxt.sdet = 1; nxt.pdet = 1; cycle("R9 both together");
    nxt.sdet = 1; cycle("R9 start before disable");
    nxt.en = 0; cycle("R9 disable clears");
    nxt.en = 1; cycle("R9 re-enable");

    // Acknowledge
    nxt.sda = 0; nxt.c9 = 1; cycle("R10 ack low");
    nxt.sda = 1; nxt.c9 = 1; cycle("R10 nack high");
    nxt.sda = 0; nxt.c9 = 1; cycle("R10 ack again");
    nxt.sdet = 1; cycle("R10 start clears ack");
    nxt.c9 = 1; cycle("R10 ack reload");
    nxt.c9 = 1; nxt.pdet = 1; cycle("R10 stop beats load");

    // Direction
    nxt.dir = 1; cycle("R11 transmit");
    cycle("R11 held");
    nxt.dir = 0; cycle("R11 receive");

    repeat (3) @(posedge clk);
    #6;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule